// File: doc/BRIEF.md
# Configuration Sequencer for a Programmable Logic Device

This block is the top-level sequencer for the power-up and reprogram flow of a configurable logic device. After a power-on reset it waits out a power-on delay counted in timer ticks. The delay is longer when the mode pins select master mode. It then clears the configuration memory and waits for the device reset pin to go inactive. It then samples the mode pins and enables the bitstream loader. When the loader reports completion, the block runs a short start-up and releases the user I/O.

While loading, a device reset held low for a few timer ticks aborts the load back to memory clear. When operational, a falling edge on the combined done/program pin, followed by a long enough low time, starts a reprogram. If that pin has stayed low since start-up, the reset pin takes over this role. A power-down request parks the device and returns it to operation when it is removed.

The states are POWERON, CLEAR, CONFIG, STARTUP, OPER and PWRDN. The transitions are:
- POWERON to CLEAR when the delay expires.
- CLEAR to CONFIG when the clear time has elapsed and the reset pin is high.
- CONFIG to CLEAR on an abort.
- CONFIG to STARTUP on loader completion.
- STARTUP to OPER when the start-up time has elapsed.
- OPER to CLEAR on a reprogram trigger.
- OPER to PWRDN on a power-down request.
- PWRDN to OPER on release.

Top module: `cfgseq_top`

## Requirements
- R1: While `por_n` is low and in POWERON: `init_low`=1, `hdc`=1, `ldc`=0, `io_tristate`=1, `clr_mem`=0, `loader_en`=0 and `mode_sample`=0.
- R2: POWERON lasts until the 2^POR_SHORT_LOG2-th tick when `mode` differs from MASTER_MODE (default 3'b000), or until the 2^POR_LONG_LOG2-th tick when `mode` equals MASTER_MODE. `mode` is held steady during this time. `clr_mem` is 1 in the cycle after the posedge that takes the final tick.
- R3: CLEAR drives `clr_mem`=1 and `init_low`=1. With `pin_reset_n` high throughout, it lasts exactly CLR_CYCLES clock cycles.
- R4: CLEAR is not left while `pin_reset_n` is low, even after CLR_CYCLES. The first posedge that samples `pin_reset_n` high after that time moves to CONFIG.
- R5: In CONFIG, `loader_en`=1 and `init_low`=0. `mode_sample` is 1 only in the first CONFIG cycle after each entry from CLEAR.
- R6: In CONFIG, `pin_reset_n` sampled low on ABORT_TICKS (default 3) consecutive ticks, with no high sample between them, returns the block to CLEAR. A high sample restarts the count, and cycles without a tick do not advance it.
- R7: `cfg_done` in CONFIG moves to STARTUP, where `loader_en`=0 and `io_tristate`=1. After SU_CYCLES cycles in STARTUP the block enters OPER with `io_tristate`=0.
- R8: `hdc`=1 and `ldc`=0 in POWERON, CLEAR and CONFIG. `hdc`=0 and `ldc`=1 in STARTUP, OPER and PWRDN. `io_tristate`=0 only in OPER.
- R9: In OPER, if `done_prog` has been high since STARTUP, a high-to-low edge on `done_prog` followed by PROG_LOW_TICKS low ticks (counting the edge cycle) triggers a move to CLEAR. A return high before the final tick cancels the trigger.
- R10: In OPER, if `done_prog` has been low since entering STARTUP, `done_prog` cannot trigger a reprogram. The same edge-plus-low-ticks rule then applies to `pin_reset_n` instead.
- R11: In OPER, `pwrdn_req`=1 moves to PWRDN (`io_tristate`=1), which holds while `pwrdn_req` stays 1. Its release returns to OPER on the next posedge.
- R12: In OPER, when `done_prog` has been high since STARTUP, `pin_reset_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Timer tick, one-cycle qualifier |
| pin_reset_n | input | 1 | Device reset pin, active low |
| done_prog | input | 1 | Combined done/program pin level |
| mode | input | MODE_W | Mode pins |
| pwrdn_req | input | 1 | Power-down request |
| cfg_done | input | 1 | Loader reports configuration complete |
| init_low | output | 1 | Pull the open-drain INIT line low |
| hdc | output | 1 | High during configuration |
| ldc | output | 1 | Low during configuration |
| clr_mem | output | 1 | Clear configuration memory |
| io_tristate | output | 1 | Hold user I/O in high impedance |
| mode_sample | output | 1 | Strobe to capture the mode pins |
| loader_en | output | 1 | Enable the bitstream loader |

## Verification
The power-on delay is tried with irregular random tick patterns and with ticks on every cycle. This shows that ticks, not clocks, are counted, and that the master mode code selects the longer delay. Random reset-pin levels and ticks during loading are compared with a model of consecutive low ticks. This separates a true abort from runs broken by a high sample and from low levels that carry no tick. Directed sequences cover these cases:
- a low pulse one tick short of the reprogram threshold, against one that reaches it;
- a reset pin ignored while done/program is usable, against the reset pin taking over when done/program has stayed low;
- a reset held low in CLEAR, against a reset released there.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [2:0] {
        ST_POWERON = 3'd0,
        ST_CLEAR   = 3'd1,
        ST_CONFIG  = 3'd2,
        ST_STARTUP = 3'd3,
        ST_OPER    = 3'd4,
        ST_PWRDN   = 3'd5
    } cfg_state_e;

endpackage

// File: rtl/cfgseq_span.sv
// Counts steps inside one state and saturates at a limit; restarts on a state change.
module cfgseq_span #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [CNT_W-1:0] last,
    output logic             hit
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (step && (cnt_q != last)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        hit = step && (cnt_q == last);
    end

endmodule

// File: rtl/cfgseq_lowtime.sv
// Measures how many ticks a level stays low; optionally requires a falling edge to start.
module cfgseq_lowtime #(
    parameter int TICKS     = 3,
    parameter bit NEED_EDGE = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic en,
    input  logic level,
    input  logic tick,
    output logic fire
);

    localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic          start;
    logic          run;
    logic [CW-1:0] cnt_eff;

    generate
        if (NEED_EDGE) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    prev_q <= 1'b0;
                end else begin
                    prev_q <= level;
                end
            end
            always_comb begin
                start = !active_q && prev_q && !level;
            end
        end else begin : g_level
            always_comb begin
                start = !active_q;
            end
        end
    endgenerate

    always_comb begin
        run     = en && !level && (active_q || start);
        cnt_eff = active_q ? cnt_q : '0;
        fire    = run && tick && (cnt_eff == LAST);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (!en || level) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (run) begin
            active_q <= 1'b1;
            if (tick && (cnt_eff != LAST)) begin
                cnt_q <= cnt_eff + CW'(1);
            end else begin
                cnt_q <= cnt_eff;
            end
        end
    end

endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top #(
    parameter int MODE_W         = 3,
    parameter int MASTER_MODE    = 0,
    parameter int POR_SHORT_LOG2 = 14,
    parameter int POR_LONG_LOG2  = 16,
    parameter int CLR_CYCLES     = 16,
    parameter int SU_CYCLES      = 3,
    parameter int ABORT_TICKS    = 3,
    parameter int PROG_LOW_TICKS = 6
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              tick,
    input  logic              pin_reset_n,
    input  logic              done_prog,
    input  logic [MODE_W-1:0] mode,
    input  logic              pwrdn_req,
    input  logic              cfg_done,
    output logic              init_low,
    output logic              hdc,
    output logic              ldc,
    output logic              clr_mem,
    output logic              io_tristate,
    output logic              mode_sample,
    output logic              loader_en
);

    import cfgseq_pkg::*;

    localparam int POR_MAX_LOG2 = (POR_LONG_LOG2 > POR_SHORT_LOG2) ? POR_LONG_LOG2 : POR_SHORT_LOG2;
    localparam int CLR_W        = $clog2(CLR_CYCLES + 1);
    localparam int SU_W         = $clog2(SU_CYCLES + 1);
    localparam int CNT_A        = (POR_MAX_LOG2 + 1 > CLR_W) ? POR_MAX_LOG2 + 1 : CLR_W;
    localparam int CNT_W        = (CNT_A > SU_W) ? CNT_A : SU_W;
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((2 ** POR_SHORT_LOG2) - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'((2 ** POR_LONG_LOG2) - 1);
    localparam logic [CNT_W-1:0] CLR_LAST   = CNT_W'(CLR_CYCLES - 1);
    localparam logic [CNT_W-1:0] SU_LAST    = CNT_W'(SU_CYCLES - 1);

    cfg_state_e       state_q, state_d;
    logic             fresh_q;
    logic             seen_high_q, seen_high_d;
    logic             is_master;
    logic [CNT_W-1:0] span_last;
    logic             span_step;
    logic             span_restart;
    logic             span_hit;
    logic             abort_fire;
    logic             prog_fire;
    logic             rpin_fire;
    logic             reprog;
    logic             in_config;
    logic             prog_path_en;
    logic             rpin_path_en;

    // ---------------- span counter selection ----------------
    always_comb begin
        is_master = (mode == MODE_W'(MASTER_MODE));
        span_step = 1'b1;
        span_last = '0;
        unique case (state_q)
            ST_POWERON: begin
                span_step = tick;
                span_last = is_master ? LONG_LAST : SHORT_LAST;
            end
            ST_CLEAR:   span_last = CLR_LAST;
            ST_STARTUP: span_last = SU_LAST;
            default:    span_last = '0;
        endcase
        span_restart = (state_d != state_q);
    end

    cfgseq_span #(
        .CNT_W (CNT_W)
    ) span_u (
        .clk     (clk),
        .arst_n  (por_n),
        .restart (span_restart),
        .step    (span_step),
        .last    (span_last),
        .hit     (span_hit)
    );

    // ---------------- low-time detectors ----------------
    always_comb begin
        in_config    = (state_q == ST_CONFIG);
        prog_path_en = (state_q == ST_OPER) && seen_high_q;
        rpin_path_en = (state_q == ST_OPER) && !seen_high_q;
    end

    cfgseq_lowtime #(
        .TICKS     (ABORT_TICKS),
        .NEED_EDGE (1'b0)
    ) abort_u (
        .clk    (clk),
        .arst_n (por_n),
        .en     (in_config),
        .level  (pin_reset_n),
        .tick   (tick),
        .fire   (abort_fire)
    );

    cfgseq_lowtime #(
        .TICKS     (PROG_LOW_TICKS),
        .NEED_EDGE (1'b1)
    ) prog_u (
        .clk    (clk),
        .arst_n (por_n),
        .en     (prog_path_en),
        .level  (done_prog),
        .tick   (tick),
        .fire   (prog_fire)
    );

    cfgseq_lowtime #(
        .TICKS     (PROG_LOW_TICKS),
        .NEED_EDGE (1'b1)
    ) rpin_u (
        .clk    (clk),
        .arst_n (por_n),
        .en     (rpin_path_en),
        .level  (pin_reset_n),
        .tick   (tick),
        .fire   (rpin_fire)
    );

    always_comb begin
        reprog = prog_fire || rpin_fire;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWERON: if (span_hit) state_d = ST_CLEAR;
            ST_CLEAR:   if (span_hit && pin_reset_n) state_d = ST_CONFIG;
            ST_CONFIG: begin
                if (abort_fire)    state_d = ST_CLEAR;
                else if (cfg_done) state_d = ST_STARTUP;
            end
            ST_STARTUP: if (span_hit) state_d = ST_OPER;
            ST_OPER: begin
                if (reprog)         state_d = ST_CLEAR;
                else if (pwrdn_req) state_d = ST_PWRDN;
            end
            ST_PWRDN:   if (!pwrdn_req) state_d = ST_OPER;
            default:    state_d = ST_POWERON;
        endcase
    end

    always_comb begin
        if ((state_q == ST_STARTUP) || (state_q == ST_OPER) || (state_q == ST_PWRDN)) begin
            seen_high_d = seen_high_q || done_prog;
        end else begin
            seen_high_d = 1'b0;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q     <= ST_POWERON;
            fresh_q     <= 1'b0;
            seen_high_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            fresh_q     <= (state_d != state_q);
            seen_high_q <= seen_high_d;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        init_low    = 1'b0;
        hdc         = 1'b0;
        ldc         = 1'b1;
        clr_mem     = 1'b0;
        io_tristate = 1'b1;
        mode_sample = 1'b0;
        loader_en   = 1'b0;
        unique case (state_q)
            ST_POWERON: begin
                init_low = 1'b1;
                hdc      = 1'b1;
                ldc      = 1'b0;
            end
            ST_CLEAR: begin
                init_low = 1'b1;
                hdc      = 1'b1;
                ldc      = 1'b0;
                clr_mem  = 1'b1;
            end
            ST_CONFIG: begin
                hdc         = 1'b1;
                ldc         = 1'b0;
                loader_en   = 1'b1;
                mode_sample = fresh_q;
            end
            ST_STARTUP: io_tristate = 1'b1;
            ST_OPER:    io_tristate = 1'b0;
            ST_PWRDN:   io_tristate = 1'b1;
            default:    io_tristate = 1'b1;
        endcase
    end

    // ---------------- assertions ----------------
    // R4
    clear_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_CLEAR && !pin_reset_n) |=> clr_mem);

    // R5
    sample_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        mode_sample |=> !mode_sample);

    // R5
    sample_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
        mode_sample |-> ($past(state_q) == ST_CLEAR));

    // R6
    abort_exit_chk: assert property (@(posedge clk) disable iff (!por_n)
        abort_fire |=> clr_mem);

    // R8
    io_hdc_chk: assert property (@(posedge clk) disable iff (!por_n)
        !io_tristate |-> (!hdc && ldc && !init_low));

    // R9
    reprog_exit_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_OPER && reprog) |=> (clr_mem && io_tristate));

    // R11
    pwrdn_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_PWRDN && pwrdn_req) |=> io_tristate);

    // R1
    por_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_POWERON) |=> !loader_en);

endmodule

// File: tb/tb_cfgseq_top.sv
module tb_cfgseq_top;

    localparam int SHORT_N = 16;
    localparam int LONG_N  = 32;
    localparam int CLR_N   = 8;
    localparam int SU_N    = 3;
    localparam int PROG_N  = 5;

    logic       clk = 1'b0;
    logic       por_n, tick, pin_reset_n, done_prog, pwrdn_req, cfg_done;
    logic [2:0] mode;
    logic       init_low, hdc, ldc, clr_mem, io_tristate, mode_sample, loader_en;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;
    int  seed_val;

    always #4 clk = ~clk;

    cfgseq_top #(
        .MODE_W         (3),
        .MASTER_MODE    (0),
        .POR_SHORT_LOG2 (4),
        .POR_LONG_LOG2  (5),
        .CLR_CYCLES     (CLR_N),
        .SU_CYCLES      (SU_N),
        .ABORT_TICKS    (3),
        .PROG_LOW_TICKS (PROG_N)
    ) dut (
        .clk         (clk),
        .por_n       (por_n),
        .tick        (tick),
        .pin_reset_n (pin_reset_n),
        .done_prog   (done_prog),
        .mode        (mode),
        .pwrdn_req   (pwrdn_req),
        .cfg_done    (cfg_done),
        .init_low    (init_low),
        .hdc         (hdc),
        .ldc         (ldc),
        .clr_mem     (clr_mem),
        .io_tristate (io_tristate),
        .mode_sample (mode_sample),
        .loader_en   (loader_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit abort_now(input bit rn, input bit tk, input int run);
        return !rn && tk && (run == 2);
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int  seen;
        int  n;
        bit  ok;
        seed_val    = $urandom(32'd4242);
        por_n       = 1'b0;
        tick        = 1'b0;
        pin_reset_n = 1'b1;
        done_prog   = 1'b1;
        mode        = 3'b011;
        pwrdn_req   = 1'b0;
        cfg_done    = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk_eq("R1 init_low", init_low, 1);
        chk_eq("R1 hdc", hdc, 1);
        chk_eq("R1 ldc", ldc, 0);
        chk_eq("R1 io_tristate", io_tristate, 1);
        chk_eq("R1 clr_mem", clr_mem, 0);
        chk_eq("R1 loader_en", loader_en, 0);
        chk_eq("R1 mode_sample", mode_sample, 0);
        por_n = 1'b1;

        // R2 short delay with irregular ticks
        seen = 0; ok = 1;
        while (seen < SHORT_N) begin
            tick = (($urandom % 3) != 0);
            if (tick) seen++;
            cyc();
            if (seen < SHORT_N && clr_mem) ok = 0;
            if (seen < SHORT_N && !init_low) ok = 0;
        end
        tick = 1'b0;
        chk_eq("R2 no early clear", ok, 1);
        chk_eq("R2 clear after final tick", clr_mem, 1);

        // R3 clear length
        n = 0; ok = 1;
        while (clr_mem && n < 100) begin
            n++;
            if (!init_low) ok = 0;
            cyc();
        end
        chk_eq("R3 clear cycles", n, CLR_N);
        chk_eq("R3 init low in clear", ok, 1);
        chk_eq("R5 mode_sample", mode_sample, 1);
        chk_eq("R5 loader_en", loader_en, 1);
        chk_eq("R5 init released", init_low, 0);
        chk_eq("R8 hdc config", hdc, 1);
        cyc();
        chk_eq("R5 mode_sample single", mode_sample, 0);

        // R6 random abort against model
        for (int t = 0; t < 5; t++) begin
            int run;
            bit fired;
            run = 0;
            fired = 0;
            for (int k = 0; k < 60 && !fired; k++) begin
                bit rn;
                bit tk;
                rn = (($urandom % 100) < 50);
                tk = (($urandom % 100) < 70);
                pin_reset_n = rn;
                tick = tk;
                fired = abort_now(rn, tk, run);
                run = rn ? 0 : run + int'(tk);
                cyc();
                if (fired) chk_eq("R6 abort clear", clr_mem, 1);
                else       chk_eq("R6 still loading", loader_en, 1);
            end
            tick = 1'b0;
            if (fired) begin
                pin_reset_n = 1'b0;
                repeat (CLR_N + 4) cyc();
                chk_eq("R4 held in clear", clr_mem, 1);
                pin_reset_n = 1'b1;
                cyc();
                chk_eq("R4 leaves clear", clr_mem, 0);
                chk_eq("R5 resample", mode_sample, 1);
            end else begin
                pin_reset_n = 1'b1;
                cyc();
            end
        end

        // R6 directed: two low ticks then high, then low without ticks
        pin_reset_n = 1'b0; tick = 1'b1;
        repeat (2) cyc();
        pin_reset_n = 1'b1;
        cyc();
        chk_eq("R6 two ticks no abort", loader_en, 1);
        pin_reset_n = 1'b0; tick = 1'b1;
        repeat (2) cyc();
        tick = 1'b0;
        repeat (5) cyc();
        chk_eq("R6 no tick no abort", loader_en, 1);
        pin_reset_n = 1'b1;
        cyc();

        // R7 start-up
        cfg_done = 1'b1;
        cyc();
        cfg_done = 1'b0;
        chk_eq("R7 loader off", loader_en, 0);
        chk_eq("R8 hdc startup", hdc, 0);
        chk_eq("R8 ldc startup", ldc, 1);
        n = 0;
        while (io_tristate && n < 50) begin
            n++;
            cyc();
        end
        chk_eq("R7 startup cycles", n, SU_N);
        chk_eq("R8 io enabled", io_tristate, 0);
        chk_eq("R8 ldc oper", ldc, 1);

        // R12 reset pin ignored
        pin_reset_n = 1'b0; tick = 1'b1; ok = 1;
        repeat (10) begin
            cyc();
            if (io_tristate || clr_mem) ok = 0;
        end
        chk_eq("R12 reset ignored", ok, 1);
        pin_reset_n = 1'b1;
        cyc();

        // R11 power-down
        pwrdn_req = 1'b1;
        cyc();
        chk_eq("R11 enter pwrdn", io_tristate, 1);
        repeat (3) cyc();
        chk_eq("R11 hold pwrdn", io_tristate, 1);
        chk_eq("R11 no clear", clr_mem, 0);
        pwrdn_req = 1'b0;
        cyc();
        chk_eq("R11 back to oper", io_tristate, 0);

        // R9 cancel one tick short
        done_prog = 1'b0; tick = 1'b1;
        repeat (PROG_N - 1) cyc();
        done_prog = 1'b1;
        cyc();
        chk_eq("R9 cancelled", io_tristate, 0);
        chk_eq("R9 no clear", clr_mem, 0);

        // R9 trigger with irregular ticks
        done_prog = 1'b0; seen = 0; ok = 1;
        while (seen < PROG_N) begin
            tick = (($urandom % 2) == 1);
            if (tick) seen++;
            cyc();
            if (seen < PROG_N && io_tristate) ok = 0;
        end
        tick = 1'b0;
        chk_eq("R9 oper until trigger", ok, 1);
        chk_eq("R9 reprogram clear", clr_mem, 1);
        done_prog = 1'b1;
        n = 0;
        while (clr_mem && n < 100) begin n++; cyc(); end
        chk_eq("R9 back to config", mode_sample, 1);

        // R10 fallback to reset pin
        done_prog = 1'b0;
        cfg_done = 1'b1;
        cyc();
        cfg_done = 1'b0;
        n = 0;
        while (io_tristate && n < 50) begin n++; cyc(); end
        tick = 1'b1; ok = 1;
        repeat (10) begin
            cyc();
            if (io_tristate) ok = 0;
        end
        chk_eq("R10 low prog ignored", ok, 1);
        pin_reset_n = 1'b0;
        repeat (PROG_N - 2) cyc();
        pin_reset_n = 1'b1;
        cyc();
        chk_eq("R10 short reset cancelled", io_tristate, 0);
        pin_reset_n = 1'b0;
        repeat (PROG_N - 1) cyc();
        chk_eq("R10 not yet", io_tristate, 0);
        cyc();
        chk_eq("R10 reset reprogram", clr_mem, 1);
        repeat (CLR_N + 4) cyc();
        chk_eq("R4 clear held by reset", clr_mem, 1);
        pin_reset_n = 1'b1;
        cyc();
        chk_eq("R4 released", mode_sample, 1);
        done_prog = 1'b1;

        // R2 master mode long delay
        tick = 1'b0;
        por_n = 1'b0;
        mode = 3'b000;
        repeat (2) cyc();
        por_n = 1'b1; tick = 1'b1;
        n = 0;
        while (!clr_mem && n < 200) begin n++; cyc(); end
        chk_eq("R2 master delay", n, LONG_N);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule